// File: doc/BRIEF.md
# Multi-format slave serial audio port

This block is the digital audio data port of a stereo converter operating as a slave. An external master supplies the bit clock and the word select. Word select low marks the left channel and high marks the right channel. The port turns the playback bit stream arriving on the serial input into parallel left and right words. It also turns the parallel record words into a serial stream on the data output. Everything runs on one fast system clock that oversamples the bit clock. The incoming bits are taken on the bit-clock rising edge, and the output changes after the bit-clock falling edge.

A 3-bit format code selects the framing, and receive framing and transmit framing are decoded separately:

- Code 000 is I2S in both directions.
- Code 100 is MSB-justified in both directions.
- Codes 001, 010 and 011 are LSB-justified in both directions, with words of 16, 18 and 20 bits.
- Codes 101, 110 and 111 receive LSB-justified words of 16, 18 or 20 bits and transmit MSB-justified words in the same frame.

Received words come out left-aligned in 20 bits, or sign-extended for the right-aligned formats. A left/right pair is presented together with a single-cycle strobe.

Top module: `serial_audio_port`

## Requirements
- R1: With code 000 (I2S receive), the bit sampled on the second bit-clock rising edge after a word-select change is the word MSB. Up to 20 bits are collected left-aligned, so bit 19 is the MSB. Unsent trailing positions stay 0. The bit in the first slot and any bits past the 20th are ignored.
- R2: With code 100 (MSB-justified receive), the bit sampled on the first rising edge after a word-select change is the MSB. Otherwise the behaviour is as in R1: left-aligned, at most 20 bits, later bits ignored.
- R3: With codes 001/101 (16 bits), 010/110 (18 bits) and 011/111 (20 bits), the N bits sampled last before the word-select change form the word. The bit sampled last is the LSB. The word is sign-extended to 20 bits, and bits earlier in the half-frame are ignored.
- R4: The half-frame with word select low is the left word and the half-frame with word select high is the right word. When a right word completes, rx_left and rx_right are updated together and rx_valid is high for exactly one clock. No strobe is produced without a completed pair.
- R5: With code 000 (I2S transmit), slot 0 after a word-select change carries 0. Slots 1 to 20 carry tx bits 19 down to 0, and later slots carry 0. tx_left is used while word select is low and tx_right while it is high.
- R6: With codes 100 to 111 (MSB-justified transmit), slots 0 to 19 carry tx bits 19 down to 0, and later slots carry 0.
- R7: With codes 001/010/011 (LSB-justified transmit, N = 16/18/20), the last N slots of each half-frame carry tx bits N-1 down to 0, ending with the LSB. Earlier slots carry 0. The half-frame length is the length measured in the previous half-frame.
- R8: After reset, sdo, rx_valid, rx_left and rx_right are all 0.
- R9: sdo changes only in the clock that follows a detected bit-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the master: 0 for left, 1 for right |
| sdi | input | 1 | Serial playback data |
| fmt | input | 3 | Format code |
| tx_left | input | 20 | Left record word to transmit |
| tx_right | input | 20 | Right record word to transmit |
| sdo | output | 1 | Serial record data |
| rx_left | output | 20 | Last received left word |
| rx_right | output | 20 | Last received right word |
| rx_valid | output | 1 | One-clock strobe when a new pair is presented |

## Verification
All eight format codes are swept with 32-slot half-frames and pseudo-random left and right words. Each half-frame is built arithmetically for the code under test.

In the left-aligned formats, both 20-bit and 16-bit words are sent, with ones placed in the slots that must be ignored. This separates the one-slot I2S offset from the zero offset, and it shows that a 20-bit cap is applied. In the right-aligned formats, the leading slots are filled with a garbage pattern and the word's sign bit is varied. This tells the 16, 18 and 20-bit lengths apart and exposes wrong sign extension.

The serial output is captured slot by slot in every half-frame. The combined codes show that transmit framing stays MSB-justified while receive framing is right-aligned.

// File: rtl/sap_pkg.sv
package sap_pkg;

    typedef enum logic [1:0] {
        FR_I2S = 2'd0,
        FR_MSB = 2'd1,
        FR_LSB = 2'd2
    } frame_e;

    // receive framing: 000 I2S, 100 MSB-justified, everything else right-aligned
    function automatic frame_e rx_frame(input logic [2:0] code);
        if (code == 3'b000)      return FR_I2S;
        else if (code == 3'b100) return FR_MSB;
        else                     return FR_LSB;
    endfunction

    // transmit framing: 000 I2S, 001..011 right-aligned, 1xx MSB-justified
    function automatic frame_e tx_frame(input logic [2:0] code);
        if (code == 3'b000)  return FR_I2S;
        else if (code[2])    return FR_MSB;
        else                 return FR_LSB;
    endfunction

    // right-aligned word length: sel 1/2/3 -> max-4 / max-2 / max
    function automatic int lsb_len(input logic [1:0] sel, input int max_w);
        return max_w - 2 * (3 - int'(sel));
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bck,
    input  logic ws,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic ws_s,
    output logic sdi_s
);
    typedef struct packed {
        logic bck1;
        logic bck2;
        logic ws1;
        logic sdi1;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.bck1 = bck;
        d.bck2 = q.bck1;
        d.ws1  = ws;
        d.sdi1 = sdi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise  = q.bck1 & ~q.bck2;
    assign fall  = ~q.bck1 & q.bck2;
    assign ws_s  = q.ws1;
    assign sdi_s = q.sdi1;
endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              ws_s,
    input  logic              sdi_s,
    input  logic [2:0]        fmt,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              ws_prev;
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] msbw;
        logic [WORD_W-1:0] lhold;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic              valid;
    } rx_t;

    rx_t q, d;

    function automatic logic [WORD_W-1:0] sext(input logic [WORD_W-1:0] v, input int len);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = (i < len) ? v[i] : v[len-1];
        return r;
    endfunction

    always_comb begin
        frame_e            mode;
        logic              trans;
        logic [CNT_W-1:0]  slot;
        logic [WORD_W-1:0] done;
        int                idx;
        d     = q;
        d.valid = 1'b0;
        mode  = rx_frame(fmt);
        trans = ws_s != q.ws_prev;
        done  = (mode == FR_LSB) ? sext(q.sh, lsb_len(fmt[1:0], WORD_W)) : q.msbw;
        slot  = q.cnt;
        idx   = 0;
        if (rise) begin
            if (trans) begin
                if (q.armed) begin
                    if (!q.ws_prev) begin
                        d.lhold = done;
                    end else begin
                        d.left  = q.lhold;
                        d.right = done;
                        d.valid = 1'b1;
                    end
                end
                d.armed = 1'b1;
                slot    = '0;
                d.sh    = '0;
                d.msbw  = '0;
            end
            d.sh = {d.sh[WORD_W-2:0], sdi_s};
            idx  = int'(slot) - ((mode == FR_I2S) ? 1 : 0);
            if (idx >= 0 && idx < WORD_W) d.msbw[WORD_W-1-idx] = sdi_s;
            d.cnt     = (slot == CNT_MAX) ? slot : slot + 1'b1;
            d.ws_prev = ws_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.ws_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_left  = q.left;
    assign rx_right = q.right;
    assign rx_valid = q.valid;

    // R4: a strobe only follows a sampled bit-clock edge
    p_valid_after_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(rise));
    // R4: strobe is one clock wide
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);
    // R3: a channel change restarts slot numbering
    p_slot_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (ws_s != q.ws_prev)) |=> (q.cnt == 1));
    // R4: output words hold between strobes
    p_words_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> ($stable(q.left) && $stable(q.right)));
endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              ws_s,
    input  logic [2:0]        fmt,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic              sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              ws_prev;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W:0]    len;
        logic [WORD_W-1:0] word;
        logic              sdo;
    } tx_t;

    tx_t q, d;

    always_comb begin
        frame_e            mode;
        logic              trans;
        logic [CNT_W-1:0]  slot;
        logic [WORD_W-1:0] cur;
        int                idx;
        d     = q;
        mode  = tx_frame(fmt);
        trans = ws_s != q.ws_prev;
        slot  = (q.cnt == CNT_MAX) ? q.cnt : q.cnt + 1'b1;
        cur   = q.word;
        idx   = -1;
        if (fall) begin
            if (trans) begin
                slot   = '0;
                d.len  = {1'b0, q.cnt} + 1'b1;
                cur    = ws_s ? tx_right : tx_left;
                d.word = cur;
            end
            d.sdo = 1'b0;
            unique case (mode)
                FR_I2S: begin
                    idx = int'(slot) - 1;
                    if (idx >= 0 && idx < WORD_W) d.sdo = cur[WORD_W-1-idx];
                end
                FR_MSB: begin
                    idx = int'(slot);
                    if (idx < WORD_W) d.sdo = cur[WORD_W-1-idx];
                end
                default: begin
                    idx = int'(q.len) - 1 - int'(slot);
                    if (idx >= 0 && idx < lsb_len(fmt[1:0], WORD_W)) d.sdo = cur[idx];
                end
            endcase
            d.cnt     = slot;
            d.ws_prev = ws_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.ws_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sdo = q.sdo;

    // R9: output moves only after a bit-clock falling edge
    p_sdo_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(q.sdo));
    // R7: a channel change starts a new half-frame at slot 0
    p_tx_slot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && (ws_s != q.ws_prev)) |=> (q.cnt == 0));
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
    parameter int WORD_W = 20,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck,
    input  logic              ws,
    input  logic              sdi,
    input  logic [2:0]        fmt,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic              sdo,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    logic rise, fall, ws_s, sdi_s;

    sap_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bck(bck), .ws(ws), .sdi(sdi),
        .rise(rise), .fall(fall), .ws_s(ws_s), .sdi_s(sdi_s)
    );

    sap_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .ws_s(ws_s), .sdi_s(sdi_s),
        .fmt(fmt), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    sap_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall(fall), .ws_s(ws_s), .fmt(fmt),
        .tx_left(tx_left), .tx_right(tx_right), .sdo(sdo)
    );
endmodule

// File: tb/serial_audio_port_tb.sv
module serial_audio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b1, ws = 1'b0, sdi = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic [19:0] tx_left = '0, tx_right = '0;
    logic        sdo, rx_valid;
    logic [19:0] rx_left, rx_right;

    int checks = 0, errors = 0, vcnt = 0, last_vcnt = 0;
    logic [19:0] got_l, got_r;
    logic        pend = 1'b0;
    logic [19:0] pend_l, pend_r;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    serial_audio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bck(bck), .ws(ws), .sdi(sdi), .fmt(fmt),
        .tx_left(tx_left), .tx_right(tx_right), .sdo(sdo),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    always @(negedge clk) if (rx_valid) begin
        got_l <= rx_left;
        got_r <= rx_right;
        vcnt  <= vcnt + 1;
    end

    function automatic logic [19:0] rnd20();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[27:8];
    endfunction

    function automatic int nlen(input logic [1:0] s);
        return 20 - 2 * (3 - int'(s));
    endfunction

    // serial input vector for a half-frame; bit 31-t is slot t
    function automatic logic [31:0] rx_vec(input logic [2:0] f, input logic [19:0] w, input int wl);
        logic [31:0] v = '0;
        int n;
        if (f == 3'b000 || f == 3'b100) begin
            int off = (f == 3'b000) ? 1 : 0;
            for (int t = 0; t < 32; t++) begin
                int i = t - off;
                if (i < 0 || i >= 20) v[31-t] = 1'b1;
                else if (i < wl)      v[31-t] = w[19-i];
            end
        end else begin
            n = nlen(f[1:0]);
            for (int t = 0; t < 32; t++) begin
                int k = 31 - t;
                v[31-t] = (k < n) ? w[k] : t[0];
            end
        end
        return v;
    endfunction

    function automatic logic [19:0] rx_exp(input logic [2:0] f, input logic [19:0] w, input int wl);
        logic [19:0] r;
        int n;
        if (f == 3'b000 || f == 3'b100) begin
            r = w;
            for (int i = 0; i < 20 - wl; i++) r[i] = 1'b0;
        end else begin
            n = nlen(f[1:0]);
            for (int i = 0; i < 20; i++) r[i] = (i < n) ? w[i] : w[n-1];
        end
        return r;
    endfunction

    function automatic logic [31:0] tx_exp(input logic [2:0] f, input logic [19:0] w);
        logic [31:0] v = '0;
        for (int t = 0; t < 32; t++) begin
            if (f == 3'b000) begin
                if (t >= 1 && t <= 20) v[31-t] = w[20-t];
            end else if (f[2]) begin
                if (t < 20) v[31-t] = w[19-t];
            end else begin
                if (31 - t < nlen(f[1:0])) v[31-t] = w[31-t];
            end
        end
        return v;
    endfunction

    function automatic string rx_tag(input logic [2:0] f);
        if (f == 3'b000) return "R1";
        if (f == 3'b100) return "R2";
        return "R3";
    endfunction

    function automatic string tx_tag(input logic [2:0] f);
        if (f == 3'b000) return "R5";
        if (f[2]) return "R6";
        return "R7";
    endfunction

    task automatic check_pair();
        checks++;
        if (vcnt != last_vcnt + 1 || got_l != pend_l || got_r != pend_r) begin
            errors++;
            $display("FAIL %s/R4 fmt=%b strobes=%0d exp=1 L=%h exp=%h R=%h exp=%h",
                     rx_tag(fmt), fmt, vcnt - last_vcnt, got_l, pend_l, got_r, pend_r);
        end
        last_vcnt = vcnt;
        pend = 1'b0;
    endtask

    task automatic send_half(input logic wsv, input logic [31:0] din,
                             input logic chk, input logic [31:0] exp_out);
        logic [31:0] got = '0;
        for (int t = 0; t < 32; t++) begin
            @(negedge clk);
            bck = 1'b0; ws = wsv; sdi = din[31-t];
            repeat (3) @(negedge clk);
            got[31-t] = sdo;
            @(negedge clk);
            bck = 1'b1;
            repeat (3) @(negedge clk);
            if (t == 0 && !wsv) begin
                if (pend) check_pair();
                else last_vcnt = vcnt;
            end
        end
        if (chk) begin
            checks++;
            if (got !== exp_out) begin
                errors++;
                $display("FAIL %s fmt=%b ws=%b sdo=%h exp=%h", tx_tag(fmt), fmt, wsv, got, exp_out);
            end
        end
    endtask

    task automatic send_frame(input logic chk);
        logic [19:0] wl_in = rnd20(), wr_in = rnd20();
        int wlen = seed[3] ? 16 : 20;
        tx_left  = rnd20();
        tx_right = rnd20();
        send_half(1'b0, rx_vec(fmt, wl_in, wlen), chk, tx_exp(fmt, tx_left));
        send_half(1'b1, rx_vec(fmt, wr_in, wlen), chk, tx_exp(fmt, tx_right));
        if (chk) begin
            pend   = 1'b1;
            pend_l = rx_exp(fmt, wl_in, wlen);
            pend_r = rx_exp(fmt, wr_in, wlen);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        checks++;
        if (sdo !== 1'b0 || rx_valid !== 1'b0 || rx_left !== '0 || rx_right !== '0) begin
            errors++;
            $display("FAIL R8 sdo=%b valid=%b L=%h R=%h exp=0", sdo, rx_valid, rx_left, rx_right);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int f = 0; f < 8; f++) begin
            fmt = f[2:0];
            send_frame(1'b0);
            for (int k = 0; k < 4; k++) send_frame(1'b1);
            send_frame(1'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule